// File: doc/BRIEF.md
# Block Write-Protect Register Logic

This block guards the writable storage of a small serial memory. It holds one 8-bit protection register and decides, for every array write, whether the write may go ahead. The register mixes two kinds of bit. The write-enable bit is volatile and must be set before anything can be written. The two range-select bits and the pin-qualified lock-enable bit are nonvolatile in the product. In this block they are plain flops with a reset value.

The bus front end presents each write with its address and data byte. It also presents a flag that says whether the write targets the register itself, which sits at the top address. For array writes the block answers with a combinational permit. Register writes update the register, subject to the write-enable bit and to the lock formed by the lock-enable bit and the hardware protect pin. A rejected write changes nothing. The bus side still acknowledges it, so no error path exists here.

The nonvolatile engine pulses a done input when it finishes a program cycle, and that pulse drops the write-enable bit. The register value is always visible for reads.

Top module: `wpr_guard`

## Requirements
- R1: After reset the register reads 00h and no array write is permitted.
- R2: Read layout: bit 7 is the lock-enable bit, bit 4 is range-select high, bit 3 is range-select low and bit 1 is write-enable; bits 6, 5, 2 and 0 always read 0.
- R3: While write-enable is 0, no array write is permitted.
- R4: Every register write loads write-enable from data bit 1, whatever the lock state and whatever write-enable was before.
- R5: A register write loads lock-enable and both range-select bits from data bits 7, 4 and 3 only if write-enable was 1 before that write and the lock is not active; otherwise those bits keep their value.
- R6: Range-select code {bit4,bit3} protects: 00 nothing, 01 the top quarter (C00h–FFFh at 12 address bits), 10 the top half (800h–FFFh), 11 every address. With write-enable set, an array write is permitted exactly when its address is outside the protected range.
- R7: The lock is active while lock-enable and the protect pin are both 1. A register write under lock leaves bits 7, 4 and 3 unchanged but still updates write-enable.
- R8: With the protect pin at 0, lock-enable gives no protection and can be cleared by a register write that meets the R5 condition.
- R9: A done pulse from the nonvolatile engine clears write-enable on the next edge, and it wins over a register write in the same cycle.
- R10: The permit is 0 whenever no write request is present or the request targets the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| wrReq | input | 1 | Write request present this cycle |
| regSel | input | 1 | Request targets the protection register |
| wrAddr | input | ADDR_W | Array address of the write |
| wrData | input | 8 | Data byte of the write |
| wpPin | input | 1 | Hardware protect pin |
| nvDone | input | 1 | Nonvolatile program cycle finished |
| wrPermit | output | 1 | Array write allowed |
| regRdData | output | 8 | Current register contents |

## Verification
The bench builds the block with the default 12-bit address. At that width the quarter and half boundaries fall at C00h and 800h, so each range code is probed on both sides of its edge and at the first and last addresses. The lock is exercised with the pin high and then low. This shows that write-enable stays writable under lock, that the frozen bits stay frozen, and that lock-enable can be cleared once the pin drops. The done pulse is driven in the same cycle as a register write that tries to set write-enable, which checks the priority between the two.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  localparam int REG_W   = 8;
  localparam int BIT_LCK = 7;
  localparam int BIT_RSH = 4;
  localparam int BIT_RSL = 3;
  localparam int BIT_WEN = 1;

  typedef enum logic [1:0] {
    RANGE_NONE    = 2'b00,
    RANGE_QUARTER = 2'b01,
    RANGE_HALF    = 2'b10,
    RANGE_ALL     = 2'b11
  } rangeSel_e;

  typedef struct packed {
    logic wenLoad;
    logic wenValue;
    logic wenClear;
    logic nvLoad;
  } wprStrobe_t;
endpackage

// File: rtl/wpr_ctrl.sv
module wpr_ctrl
  import wpr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrReq,
  input  logic       regSel,
  input  logic [7:0] wrData,
  input  logic       wpPin,
  input  logic       nvDone,
  input  logic       wenBit,
  input  logic       lockEn,
  input  logic       inRange,
  output wprStrobe_t strobe,
  output logic       wrPermit
);
  logic regWrite;
  logic locked;

  assign regWrite = wrReq && regSel;
  assign locked   = lockEn && wpPin;

  always_comb begin
    strobe          = '0;
    strobe.wenClear = nvDone;
    strobe.wenLoad  = regWrite && !nvDone;
    strobe.wenValue = wrData[BIT_WEN];
    strobe.nvLoad   = regWrite && wenBit && !locked;
  end

  assign wrPermit = wrReq && !regSel && wenBit && !inRange;

  // R9: done pulse and a load must never both be issued
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wenClear && strobe.wenLoad));
  // R7: no nonvolatile load while locked
  a_r7_no_load_locked: assert property (@(posedge clk) disable iff (!rstN)
    (lockEn && wpPin) |-> !strobe.nvLoad);
endmodule

// File: rtl/wpr_data.sv
module wpr_data
  import wpr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  wprStrobe_t        strobe,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] wrAddr,
  output logic              wenBit,
  output logic              lockEn,
  output logic              inRange,
  output logic [7:0]        regRdData
);
  localparam int MSB = ADDR_W - 1;

  logic      wenQ;
  logic      lockQ;
  rangeSel_e rangeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wenQ   <= 1'b0;
      lockQ  <= 1'b0;
      rangeQ <= RANGE_NONE;
    end else begin
      if (strobe.wenClear)     wenQ <= 1'b0;
      else if (strobe.wenLoad) wenQ <= strobe.wenValue;
      if (strobe.nvLoad) begin
        lockQ  <= wrData[BIT_LCK];
        rangeQ <= rangeSel_e'({wrData[BIT_RSH], wrData[BIT_RSL]});
      end
    end
  end

  always_comb begin
    unique case (rangeQ)
      RANGE_NONE:    inRange = 1'b0;
      RANGE_QUARTER: inRange = &wrAddr[MSB -: 2];
      RANGE_HALF:    inRange = wrAddr[MSB];
      default:       inRange = 1'b1;
    endcase
  end

  always_comb begin
    regRdData          = '0;
    regRdData[BIT_LCK] = lockQ;
    regRdData[BIT_RSH] = rangeQ[1];
    regRdData[BIT_RSL] = rangeQ[0];
    regRdData[BIT_WEN] = wenQ;
  end

  assign wenBit = wenQ;
  assign lockEn = lockQ;

  // R9: the done pulse leaves write-enable cleared
  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wenClear |=> !wenQ);
  // R5: without a load the protection bits hold
  a_r5_hold_nv: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.nvLoad |=> ($stable(lockQ) && $stable(rangeQ)));
endmodule

// File: rtl/wpr_guard.sv
module wpr_guard
  import wpr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrReq,
  input  logic              regSel,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              wpPin,
  input  logic              nvDone,
  output logic              wrPermit,
  output logic [7:0]        regRdData
);
  wprStrobe_t strobe;
  logic wenBit, lockEn, inRange;

  wpr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .regSel(regSel),
    .wrData(wrData), .wpPin(wpPin), .nvDone(nvDone),
    .wenBit(wenBit), .lockEn(lockEn), .inRange(inRange),
    .strobe(strobe), .wrPermit(wrPermit)
  );

  wpr_data #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .wrAddr(wrAddr), .wenBit(wenBit), .lockEn(lockEn),
    .inRange(inRange), .regRdData(regRdData)
  );

  // R3: a permit needs write-enable as read back
  a_r3_permit_needs_wen: assert property (@(posedge clk) disable iff (!rstN)
    wrPermit |-> regRdData[BIT_WEN]);
  // R6: code 11 blocks every array write
  a_r6_all_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[BIT_RSH] && regRdData[BIT_RSL]) |-> !wrPermit);
  // R2: unused bits read as zero
  a_r2_zero_bits: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData & 8'h65) == 8'h00);
  // R10: permit only for an array request
  a_r10_array_only: assert property (@(posedge clk) disable iff (!rstN)
    wrPermit |-> (wrReq && !regSel));
endmodule

// File: tb/sim_wpr_guard.sv
module sim_wpr_guard;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrReq = 1'b0, regSel = 1'b0, wpPin = 1'b0, nvDone = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic wrPermit;
  logic [7:0] regRdData;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wpr_guard #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .regSel(regSel),
    .wrAddr(wrAddr), .wrData(wrData), .wpPin(wpPin), .nvDone(nvDone),
    .wrPermit(wrPermit), .regRdData(regRdData)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] d, input logic done);
    @(negedge clk);
    wrReq = 1'b1; regSel = 1'b1; wrData = d; nvDone = done;
    @(negedge clk);
    wrReq = 1'b0; regSel = 1'b0; nvDone = 1'b0;
  endtask

  task automatic probe(input string tag, input logic [ADDR_W-1:0] a, input logic exp);
    @(negedge clk);
    wrReq = 1'b1; regSel = 1'b0; wrAddr = a;
    #1 check(tag, wrPermit, exp);
    wrReq = 1'b0;
  endtask

  function automatic logic expProt(input logic [1:0] code, input logic [ADDR_W-1:0] a);
    case (code)
      2'b00: return 1'b0;
      2'b01: return a >= 12'hC00;
      2'b10: return a >= 12'h800;
      default: return 1'b1;
    endcase
  endfunction

  task automatic testReset();
    check("R1 reset read", regRdData, 8'h00);
    probe("R1 reset permit", 12'h000, 1'b0);
  endtask

  task automatic testWen();
    regWrite(8'h02, 1'b0);
    check("R4 wen set", regRdData, 8'h02);
    probe("R6 code00 permit", 12'hFFE, 1'b1);
    regWrite(8'h00, 1'b0);
    check("R4 wen clear", regRdData, 8'h00);
    probe("R3 no wen", 12'h000, 1'b0);
  endtask

  task automatic testRanges();
    logic [ADDR_W-1:0] pts [6] = '{12'h000, 12'h7FF, 12'h800, 12'hBFF, 12'hC00, 12'hFFF};
    for (int c = 0; c < 4; c++) begin
      regWrite(8'h02, 1'b0);
      regWrite(8'((c << 3) | 2), 1'b0);
      check("R5 range load", regRdData, (c << 3) | 2);
      foreach (pts[i]) probe("R6 range permit", pts[i], !expProt(2'(c), pts[i]));
    end
    regWrite(8'h02, 1'b0);
    regWrite(8'h02, 1'b0);
  endtask

  task automatic testLayout();
    regWrite(8'hFF, 1'b0);
    check("R2 layout", regRdData, 8'h9A);
    regWrite(8'h02, 1'b0);
    check("R2 clear back", regRdData, 8'h02);
  endtask

  task automatic testNeedsWen();
    regWrite(8'h00, 1'b0);
    regWrite(8'h9A, 1'b0);
    check("R5 no load without wen", regRdData, 8'h02);
  endtask

  task automatic testDone();
    regWrite(8'h02, 1'b1);
    check("R9 done wins", regRdData, 8'h00);
    regWrite(8'h02, 1'b0);
    @(negedge clk); nvDone = 1'b1;
    @(negedge clk); nvDone = 1'b0;
    check("R9 done clears", regRdData, 8'h00);
  endtask

  task automatic testLock();
    regWrite(8'h02, 1'b0);
    regWrite(8'h82, 1'b0);
    check("R5 lock-enable set", regRdData, 8'h82);
    wpPin = 1'b1;
    regWrite(8'h9A, 1'b0);
    check("R7 frozen", regRdData, 8'h82);
    regWrite(8'h80, 1'b0);
    check("R7 wen writable", regRdData, 8'h80);
    wpPin = 1'b0;
    regWrite(8'h02, 1'b0);
    regWrite(8'h02, 1'b0);
    check("R8 unlocked clear", regRdData, 8'h02);
  endtask

  task automatic testRegNoPermit();
    @(negedge clk);
    wrReq = 1'b1; regSel = 1'b1; wrAddr = 12'h000; wrData = 8'h02;
    #1 check("R10 reg no permit", wrPermit, 0);
    @(negedge clk);
    wrReq = 1'b0; regSel = 1'b0;
    #1 check("R10 idle no permit", wrPermit, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWen();
    testRanges();
    testLayout();
    testNeedsWen();
    testDone();
    testLock();
    testRegNoPermit();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule